// File: doc/BRIEF.md
# CAN Bit Resynchronizer and Wakeup Identifier Filter

This block recovers bits from a single-wire CAN receive level so that a sleeping node can decide whether an incoming frame is worth waking up for. Time is measured in quanta; one quantum passes on every clock cycle in which `tq_tick` is high (nominally 1 µs). Each bit has one sync quantum, a first phase segment of `seg1_len` quanta and a second phase segment of `seg2_len` quanta. The level is sampled at the last quantum of the first phase segment. Every edge inside a frame moves the bit boundary to follow a transmitter whose clock drifts from the local one. The amount a single edge may move it depends on the direction of that edge.

While idle, the first recessive-to-dominant edge starts a frame and hard-synchronizes the bit timer. The bit sampled first is the start-of-frame bit. The next 12 samples form the identifier, most significant bit first. The identifier is cut into six 2-bit blocks. Each block has its own 4-bit accept mask, one bit for each value the block can take. A one-cycle match pulse is raised when every block is accepted. The block returns to idle after 11 recessive samples in a row.

Top module: `can_wake_filter`

## Requirements
- R1: While idle, a tick whose level is dominant (0) after a recessive (1) level on the previous tick starts a frame. `frame_start` pulses for one cycle after that tick, and that quantum is quantum 0 (the sync quantum) of the start-of-frame bit.
- R2: With no resynchronization, a bit lasts 1 + `seg1_len` + `seg2_len` quanta. Both lengths must be at least 1.
- R3: In each bit the level is sampled at quantum index `seg1_len`, counting the sync quantum as 0. `bit_valid` pulses for one cycle after that tick, and `bit_out` carries the sampled level (1 = recessive). `bit_out` holds its value between strobes.
- R4: An edge that falls in a bit's sync quantum changes no timing.
- R5: An edge at quantum index q, with 1 ≤ q ≤ sample index, lengthens the bit and moves the sample point later by min(q, jump width) quanta.
- R6: An edge after the sample point at quantum q, in a bit whose last index is E, ends the bit early. If E − q + 1 ≤ jump width, that quantum becomes the sync quantum of the next bit. Otherwise the second segment is shortened by the jump width.
- R7: The jump width is 1 quantum for a dominant-to-recessive edge and 1 + `jump_extra` quanta for a recessive-to-dominant edge.
- R8: The identifier is the 12 samples after the start-of-frame bit, first received = bit 11. Segment s (0..5) uses mask `filt_mask[4s+3:4s]` on identifier bits [11−2s:10−2s]. A block passes when the mask bit indexed by the block's value is 1.
- R9: `id_match` pulses for one cycle, one clock after the `bit_valid` of the 12th identifier bit, if and only if all six blocks pass.
- R10: If any segment mask is all zeros, `id_match` never pulses.
- R11: A frame ends after 11 consecutive recessive samples. Dominant edges inside a frame do not raise `frame_start`. After the frame ends, no samples are produced until the next hard synchronization.
- R12: During and right after reset, `bit_valid`, `bit_out`, `id_match` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 1 | Receive level, 0 = dominant |
| tq_tick | input | 1 | One-cycle strobe marking one time quantum |
| seg1_len | input | 4 | First phase segment length in quanta |
| seg2_len | input | 4 | Second phase segment length in quanta |
| jump_extra | input | 2 | Extra jump width for recessive-to-dominant edges |
| filt_mask | input | 24 | Six 4-bit block accept masks |
| bit_out | output | 1 | Last sampled bit |
| bit_valid | output | 1 | Sample strobe |
| id_match | output | 1 | Identifier accepted pulse |
| frame_start | output | 1 | Hard synchronization pulse |

## Verification
`frame_start`, `bit_valid` and `bit_out` are registered on the clock edge that carries the tick, so the bench reads them on the falling edge just after that tick. `id_match` is registered one clock later, so the bench reads it on the next falling edge. Each observation is tagged with the quantum index counted from the hard synchronization. The bench then compares these indices with the sample points it works out from the segment lengths. For the resynchronization scenarios it uses hand-computed shifted indices.

// File: rtl/can_wf_pkg.sv
`timescale 1ns/1ps
// Shared types of the wakeup identifier filter.
package can_wf_pkg;
    typedef enum logic {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } fr_state_t;
endpackage

// File: rtl/can_bt_timer.sv
`timescale 1ns/1ps
// Bit timer: hard sync, resynchronization and sampling, one step per quantum.
// Assumes seg1 >= 1, seg2 >= 1 and settings stable during a frame.
module can_bt_timer #(
    parameter int SEG_W = 4,
    parameter int TD_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx,
    input  logic [SEG_W-1:0] seg1,
    input  logic [SEG_W-1:0] seg2,
    input  logic [TD_W-1:0]  td,
    input  logic             in_frame,
    output logic             hard_sync,
    output logic             smp_valid,
    output logic             smp_bit
);
    localparam int CNT_W = SEG_W + 2;

    logic             rx_prev;
    logic [CNT_W-1:0] q_cnt, lim1, lim_end;
    logic [CNT_W-1:0] q_n, lim1_n, lim_end_n;
    logic             sv_n, sb_n;
    logic             edge_seen, fall_edge;
    logic [CNT_W-1:0] sjw, nom1, nom_end;

    // Edge classification and nominal limits for this quantum.
    always_comb begin
        edge_seen = tq_tick && (rx != rx_prev);
        fall_edge = edge_seen && !rx;
        hard_sync = tq_tick && !in_frame && rx_prev && !rx;
        sjw       = fall_edge ? (CNT_W'(td) + CNT_W'(1)) : CNT_W'(1);
        nom1      = CNT_W'(seg1);
        nom_end   = CNT_W'(seg1) + CNT_W'(seg2);
    end

    // Next quantum index, phase limits and sample decision.
    always_comb begin
        logic [CNT_W-1:0] l1_t, le_t, ext, need;
        logic             restart;
        q_n       = q_cnt;
        lim1_n    = lim1;
        lim_end_n = lim_end;
        sv_n      = 1'b0;
        sb_n      = smp_bit;
        l1_t      = lim1;
        le_t      = lim_end;
        ext       = '0;
        need      = '0;
        restart   = 1'b0;
        if (hard_sync) begin
            q_n       = CNT_W'(1);
            lim1_n    = nom1;
            lim_end_n = nom_end;
        end else if (tq_tick && in_frame) begin
            if (edge_seen && q_cnt != '0) begin
                if (q_cnt <= lim1) begin
                    ext  = (q_cnt < sjw) ? q_cnt : sjw;
                    l1_t = lim1 + ext;
                    le_t = lim_end + ext;
                end else begin
                    need = lim_end - q_cnt + CNT_W'(1);
                    if (need <= sjw) restart = 1'b1;
                    else             le_t    = lim_end - sjw;
                end
            end
            if (restart) begin
                q_n       = CNT_W'(1);
                lim1_n    = nom1;
                lim_end_n = nom_end;
            end else if (q_cnt == le_t) begin
                q_n       = '0;
                lim1_n    = nom1;
                lim_end_n = nom_end;
            end else begin
                q_n       = q_cnt + CNT_W'(1);
                lim1_n    = l1_t;
                lim_end_n = le_t;
            end
            if (!restart && q_cnt == l1_t) begin
                sv_n = 1'b1;
                sb_n = rx;
            end
        end
    end

    // Timer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev   <= 1'b1;
            q_cnt     <= '0;
            lim1      <= '0;
            lim_end   <= '0;
            smp_valid <= 1'b0;
            smp_bit   <= 1'b0;
        end else begin
            if (tq_tick) rx_prev <= rx;
            q_cnt     <= q_n;
            lim1      <= lim1_n;
            lim_end   <= lim_end_n;
            smp_valid <= sv_n;
            smp_bit   <= sb_n;
        end
    end
endmodule

// File: rtl/can_frame_track.sv
`timescale 1ns/1ps
// Frame tracker: marks the frame span, counts samples, finds identifier bits.
// Assumes samples arrive as one-cycle strobes from the bit timer.
module can_frame_track
    import can_wf_pkg::*;
#(
    parameter int ID_BITS  = 12,
    parameter int IDLE_RUN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hard_sync,
    input  logic smp_valid,
    input  logic smp_bit,
    output logic in_frame,
    output logic frame_start,
    output logic id_shift,
    output logic id_last
);
    localparam int IDX_W = $clog2(ID_BITS + 2);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);

    fr_state_t        state;
    logic [IDX_W-1:0] bit_idx;
    logic [RUN_W-1:0] rec_run;

    // Identifier window decode.
    always_comb begin
        in_frame = (state == FR_ACTIVE);
        id_shift = smp_valid && in_frame && (bit_idx != '0) &&
                   (bit_idx <= IDX_W'(ID_BITS));
        id_last  = id_shift && (bit_idx == IDX_W'(ID_BITS));
    end

    // Frame state, sample index and recessive run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= FR_IDLE;
            bit_idx     <= '0;
            rec_run     <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= hard_sync;
            if (hard_sync) begin
                state   <= FR_ACTIVE;
                bit_idx <= '0;
                rec_run <= '0;
            end else if (smp_valid && in_frame) begin
                if (bit_idx != IDX_W'(ID_BITS + 1)) bit_idx <= bit_idx + IDX_W'(1);
                if (smp_bit) begin
                    rec_run <= rec_run + RUN_W'(1);
                    if (rec_run == RUN_W'(IDLE_RUN - 1)) state <= FR_IDLE;
                end else begin
                    rec_run <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/can_id_filter.sv
`timescale 1ns/1ps
// Identifier filter: collects identifier bits and tests each block against its mask.
// Assumes id_last coincides with the last identifier sample.
module can_id_filter #(
    parameter int ID_BITS = 12,
    parameter int BLK_W   = 2,
    localparam int NUM_SEG = ID_BITS / BLK_W,
    localparam int MASK_W  = 1 << BLK_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      id_shift,
    input  logic                      id_last,
    input  logic                      smp_bit,
    input  logic [NUM_SEG*MASK_W-1:0] filt_mask,
    output logic                      id_match
);
    logic [ID_BITS-2:0]  id_sr;
    logic [ID_BITS-1:0]  id_full;
    logic [NUM_SEG-1:0]  blk_pass, seg_nz;

    assign id_full = {id_sr, smp_bit};

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [BLK_W-1:0]  blk;
        logic [MASK_W-1:0] msk;
        // Per-block acceptance lookup.
        always_comb begin
            blk         = id_full[ID_BITS-1-s*BLK_W -: BLK_W];
            msk         = filt_mask[s*MASK_W +: MASK_W];
            blk_pass[s] = msk[blk];
            seg_nz[s]   = |msk;
        end
    end

    // Identifier shift register and registered match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_sr    <= '0;
            id_match <= 1'b0;
        end else begin
            if (id_shift) id_sr <= id_full[ID_BITS-2:0];
            id_match <= id_last && (&blk_pass) && (&seg_nz);
        end
    end
endmodule

// File: rtl/can_wake_filter.sv
`timescale 1ns/1ps
// Top: bit recovery with edge resynchronization and a segmented identifier filter
// that flags frames worth a wakeup. Assumes tq_tick is a one-cycle strobe.
module can_wake_filter #(
    parameter int SEG_W    = 4,
    parameter int TD_W     = 2,
    parameter int ID_BITS  = 12,
    parameter int BLK_W    = 2,
    parameter int IDLE_RUN = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_level,
    input  logic             tq_tick,
    input  logic [SEG_W-1:0] seg1_len,
    input  logic [SEG_W-1:0] seg2_len,
    input  logic [TD_W-1:0]  jump_extra,
    input  logic [(ID_BITS/BLK_W)*(1<<BLK_W)-1:0] filt_mask,
    output logic             bit_out,
    output logic             bit_valid,
    output logic             id_match,
    output logic             frame_start
);
    logic hard_sync, in_frame, id_shift, id_last;

    can_bt_timer #(.SEG_W(SEG_W), .TD_W(TD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx(rx_level),
        .seg1(seg1_len), .seg2(seg2_len), .td(jump_extra),
        .in_frame(in_frame), .hard_sync(hard_sync),
        .smp_valid(bit_valid), .smp_bit(bit_out)
    );

    can_frame_track #(.ID_BITS(ID_BITS), .IDLE_RUN(IDLE_RUN)) u_track (
        .clk(clk), .rst_n(rst_n), .hard_sync(hard_sync),
        .smp_valid(bit_valid), .smp_bit(bit_out),
        .in_frame(in_frame), .frame_start(frame_start),
        .id_shift(id_shift), .id_last(id_last)
    );

    can_id_filter #(.ID_BITS(ID_BITS), .BLK_W(BLK_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .id_shift(id_shift), .id_last(id_last),
        .smp_bit(bit_out), .filt_mask(filt_mask), .id_match(id_match)
    );
endmodule

// File: rtl/can_wake_filter_chk.sv
`timescale 1ns/1ps
// Checker: port-level timing properties of the wakeup filter.
module can_wake_filter_chk #(
    parameter int ID_BITS = 12,
    parameter int BLK_W   = 2,
    localparam int NUM_SEG = ID_BITS / BLK_W,
    localparam int MASK_W  = 1 << BLK_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tq_tick,
    input logic                      rx_level,
    input logic [NUM_SEG*MASK_W-1:0] filt_mask,
    input logic                      bit_out,
    input logic                      bit_valid,
    input logic                      id_match,
    input logic                      frame_start
);
    logic [NUM_SEG-1:0] nz;
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_nz
        assign nz[s] = |filt_mask[s*MASK_W +: MASK_W];
    end

    assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(tq_tick));
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));
    assert_sof_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ($past(tq_tick) && !$past(rx_level)));
    assert_sof_no_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !bit_valid);
    assert_match_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_match |-> $past(bit_valid));
    assert_match_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_match |=> !id_match);
    assert_zero_seg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        id_match |-> (&$past(nz)));
endmodule

bind can_wake_filter can_wake_filter_chk #(.ID_BITS(ID_BITS), .BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_level(rx_level),
    .filt_mask(filt_mask), .bit_out(bit_out), .bit_valid(bit_valid),
    .id_match(id_match), .frame_start(frame_start)
);

// File: tb/can_wake_filter_tb.sv
`timescale 1ns/1ps
module can_wake_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_level = 1'b1;
    logic        tq_tick = 1'b0;
    logic [3:0]  seg1_len = 4'd2;
    logic [3:0]  seg2_len = 4'd1;
    logic [1:0]  jump_extra = 2'd0;
    logic [23:0] filt_mask = 24'hFFFFFF;
    logic        bit_out, bit_valid, id_match, frame_start;

    int checks = 0;
    int errors = 0;
    int t_q = 0;
    int nv = 0;
    int vt [0:63];
    logic vb [0:63];
    int fs_n = 0, fs_t = -1, m_n = 0, m_t = -1;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    can_wake_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tq_tick(tq_tick),
        .seg1_len(seg1_len), .seg2_len(seg2_len), .jump_extra(jump_extra),
        .filt_mask(filt_mask), .bit_out(bit_out), .bit_valid(bit_valid),
        .id_match(id_match), .frame_start(frame_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One quantum: tick with the given level, then log strobes and match.
    task automatic quantum(input logic lvl);
        @(negedge clk); rx_level = lvl; tq_tick = 1'b1;
        @(negedge clk); tq_tick = 1'b0;
        if (bit_valid) begin
            if (nv < 64) begin vt[nv] = t_q; vb[nv] = bit_out; end
            nv++;
        end
        if (frame_start) begin fs_n++; fs_t = t_q; end
        @(negedge clk);
        if (id_match) begin m_n++; m_t = t_q; end
        t_q++;
    endtask

    task automatic send_level(input logic lvl, input int nq);
        for (int i = 0; i < nq; i++) quantum(lvl);
    endtask

    task automatic clear_log();
        t_q = 0; nv = 0; fs_n = 0; fs_t = -1; m_n = 0; m_t = -1;
    endtask

    function automatic logic exp_match(input logic [11:0] id, input logic [23:0] m);
        for (int s = 0; s < 6; s++) begin
            logic [1:0] blk;
            logic [3:0] mk;
            blk = id[11-2*s -: 2];
            mk  = m[4*s +: 4];
            if (mk == 4'h0 || !mk[blk]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    // Resync scenario: three bit lengths of levels, then a recessive tail.
    task automatic scenario(input int s1, input int s2, input int td,
                            input logic l0, input int n0, input logic l1, input int n1,
                            input logic l2, input int n2, input int idx, input int exp_t,
                            input logic exp_b, input string tag);
        seg1_len = 4'(s1); seg2_len = 4'(s2); jump_extra = 2'(td);
        send_level(1'b1, 3);
        clear_log();
        send_level(l0, n0); send_level(l1, n1); send_level(l2, n2);
        send_level(1'b1, 100);
        check(nv > idx && vt[idx] == exp_t && vb[idx] == exp_b, tag,
              (nv > idx) ? vt[idx] : -1, exp_t);
    endtask

    initial begin : watchdog
        #700000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R12: reset state
        check(!bit_valid && !bit_out && !id_match && !frame_start, "R12 reset outputs",
              {bit_valid, bit_out, id_match, frame_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bit_valid && !bit_out && !id_match && !frame_start, "R12 after reset",
              {bit_valid, bit_out, id_match, frame_start}, 0);

        // R5 R7: late recessive-to-dominant edge, jump width 1+TD
        scenario(3, 2, 1, 1'b0, 6, 1'b1, 8, 1'b0, 6, 2, 17, 1'b0, "R5 R7 late fall td=1");
        scenario(3, 2, 0, 1'b0, 6, 1'b1, 8, 1'b0, 6, 2, 16, 1'b0, "R5 R7 late fall td=0");
        // R7: late dominant-to-recessive edge, jump width 1 despite TD=2
        scenario(3, 2, 2, 1'b0, 6, 1'b0, 8, 1'b1, 6, 2, 16, 1'b1, "R7 late rise td=2");
        // R6: early edge in the second segment
        scenario(3, 3, 1, 1'b0, 7, 1'b1, 5, 1'b0, 7, 2, 15, 1'b0, "R6 early fall restart");
        scenario(3, 3, 0, 1'b0, 7, 1'b1, 5, 1'b0, 7, 2, 16, 1'b0, "R6 early fall shorten");

        // R11: 10 recessive samples keep the frame open, 11 close it
        seg1_len = 4'd2; seg2_len = 4'd1; jump_extra = 2'd0;
        send_level(1'b1, 3);
        clear_log();
        send_level(1'b0, 4); send_level(1'b1, 40); send_level(1'b0, 4); send_level(1'b1, 60);
        check(fs_n == 1, "R11 no frame_start inside frame", fs_n, 1);
        check(nv > 11 && vt[11] == 46 && vb[11] == 1'b0, "R11 still sampling",
              (nv > 11) ? vt[11] : -1, 46);
        check(nv == 23, "R11 samples stop at idle", nv, 23);
        clear_log();
        send_level(1'b0, 4); send_level(1'b1, 60);
        check(fs_n == 1 && fs_t == 0, "R11 R1 new hard sync after idle", fs_t, 0);

        // R1 R2 R3 R4 R8 R9 R10: sweep of identifiers, masks and bit timings
        for (int f = 0; f < 120; f++) begin
            logic [11:0] id;
            logic [23:0] m;
            int s1, s2, nb;
            logic em;
            bit ok;
            int bad_t;
            case (f % 3)
                0: begin s1 = 2; s2 = 1; end
                1: begin s1 = 3; s2 = 2; end
                default: begin s1 = 5; s2 = 4; end
            endcase
            nb = 1 + s1 + s2;
            lcg = step(lcg);
            id = lcg[23:12] & ~12'h020;
            for (int s = 0; s < 6; s++) begin
                lcg = step(lcg);
                m[4*s +: 4] = lcg[19:16] | lcg[27:24];
            end
            if (f % 10 == 0) m = 24'hFFFFFF;
            if (f % 10 == 5) begin
                m = 24'hFFFFFF;
                m[4*(f % 6) +: 4] = 4'h0;
            end
            seg1_len = 4'(s1); seg2_len = 4'(s2); jump_extra = 2'(f % 4);
            filt_mask = m;
            em = exp_match(id, m);
            send_level(1'b1, 3);
            clear_log();
            send_level(1'b0, nb);
            for (int i = 11; i >= 0; i--) send_level(id[i], nb);
            send_level(1'b1, 13 * nb);
            check(fs_n == 1 && fs_t == 0, "R1 hard sync at SOF", fs_t, 0);
            ok = (nv >= 13) && (vb[0] == 1'b0);
            bad_t = -1;
            for (int k = 0; k < 13; k++) begin
                if (nv > k) begin
                    if (vt[k] != k * nb + s1) begin ok = 0; bad_t = vt[k]; end
                    if (k > 0 && vb[k] != id[12-k]) ok = 0;
                end
            end
            check(ok, "R2 R3 R4 sample points and bits", bad_t, s1);
            if (f % 10 == 5)
                check(m_n == 0, "R10 zero segment blocks match", m_n, 0);
            else
                check(m_n == (em ? 1 : 0), "R8 R9 match decision", m_n, em ? 1 : 0);
            if (em && m_n == 1)
                check(m_t == 12 * nb + s1, "R9 match timing", m_t, 12 * nb + s1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule